// File: doc/BRIEF.md
# Dual-Line Serial Flash Read Master

This block fetches stored calibration values, such as per-column noise offsets, from an external serial flash and passes them to an on-chip consumer. The consumer asks for a transfer by giving a 24-bit start address, a byte count and one of two fast-read variants. The block then drives the flash pins and delivers the bytes, in address order, on a valid/ready stream.

Both variants bring data back on two lines at once. In the dual I/O variant the address and a mode byte also travel on two lines. In the dual output variant the address goes out on one line and is followed by idle dummy clocks. The serial clock is derived from the system clock by a parameter. It stops at low level whenever the consumer is not draining the stream, so no byte is ever dropped.

Stream rules: `out_valid` stays high and `out_data` stays fixed until the cycle in which `out_ready` is also high. The block holds one byte. While that byte is waiting, the serial clock does not make the rising edge that would complete the next byte. A request is taken in a cycle where `req_valid` and `req_ready` are both high.

Top module: `dual_flash_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, both output enables are 0, `out_valid` is 0, `done` is 0 and `req_ready` is 1.
- R2: Each transfer begins with an 8-bit command on line 0 alone, MSB first, with line 1 released. The command is 0xBB when `req_dual_io` is 1 and 0x3B when it is 0. Line outputs and enables change only while `sclk` is low (clock mode 0, idle low).
- R3: With `req_dual_io` = 0, the 24 address bits follow MSB first on line 0, one per clock, with line 1 released. Then come 8 clocks with both lines released.
- R4: With `req_dual_io` = 1, the address follows in 12 clocks of two bits each, with line 1 carrying the higher bit of each pair. Then come 4 clocks that drive zero bits on both lines, and then data. Line 1 is never driven unless line 0 is also driven.
- R5: Data returns two bits per clock and is sampled on the rising edge. Line 1 (`io1_in`) carries the higher bit and line 0 carries the lower bit. The first pair is bits 7:6. The bytes come out for consecutive addresses, wrapping at 2^24.
- R6: When no back-pressure is present, `sclk` is high for exactly HALF_DIV system cycles and low for exactly HALF_DIV system cycles.
- R7: While a byte is held with `out_ready` low, `sclk` stays low in place of the rising edge that would complete the following byte. No byte is lost or repeated.
- R8: Once `out_valid` is high, it stays high with `out_data` unchanged until the cycle in which `out_ready` is high.
- R9: After the final data clock, `cs_n` rises HALF_DIV cycles after the last falling edge of `sclk`, and `done` is high for exactly that one cycle. `req_ready` is high only while `cs_n` is high. A transfer has exactly 8+24+8+4N clocks (dual output) or 8+12+4+4N clocks (dual I/O) for N bytes.
- R10: A request with a byte count of zero raises `done` in the next cycle and never lowers `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_addr | input | 24 | Flash start address |
| req_len | input | LEN_W | Number of bytes to read |
| req_dual_io | input | 1 | 1: address on two lines (0xBB); 0: address on one line (0x3B) |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Read byte |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Flash serial clock |
| io0_out | output | 1 | Line 0 output value |
| io0_oe | output | 1 | Line 0 output enable |
| io0_in | input | 1 | Line 0 input value |
| io1_out | output | 1 | Line 1 output value |
| io1_oe | output | 1 | Line 1 output enable |
| io1_in | input | 1 | Line 1 input value |

## Verification
The bench goes after phase boundaries, because an off-by-one beat count in the address, mode or dummy stretch shifts every data pair and turns each returned byte into a mix of two flash bytes. It swaps line roles per pair, since a design that puts the higher bit on line 0 returns bit-swapped bytes. It stalls the consumer exactly on byte-completing edges, where a design without the clock pause overwrites the held byte or emits it twice. It also covers a start address just below the 24-bit wrap point, a single-byte transfer, and a zero-length request that a careless design would turn into an endless or chip-select-only transfer.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  localparam int ADDR_W     = 24;
  localparam int BEAT_W     = 6;
  localparam int CMD_BEATS  = 8;
  localparam int ADDR1_BEATS = ADDR_W;
  localparam int ADDR2_BEATS = ADDR_W / 2;
  localparam int MODE_BEATS = 4;
  localparam int DUMMY_BEATS = 8;

  localparam logic [7:0] CMD_DUAL_IO  = 8'hBB;
  localparam logic [7:0] CMD_DUAL_OUT = 8'h3B;
  localparam logic [7:0] MODE_BITS    = 8'h00;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_MODE,
    PH_DUMMY,
    PH_DATA,
    PH_END
  } phase_t;

endpackage

// File: rtl/dfr_sclk_gen.sv
module dfr_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic sclk,
  output logic rise,
  output logic fall,
  output logic tick_lo
);

  logic last;

  assign rise    = run && !sclk && last && !hold;
  assign fall    = run && sclk && last;
  assign tick_lo = run && !sclk && last;

  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign last = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] hcnt;
      assign last = (hcnt == CW'(HALF_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hcnt <= '0;
        end else if (!run || rise || fall) begin
          hcnt <= '0;
        end else if (!last) begin
          hcnt <= hcnt + CW'(1);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk <= 1'b0;
    end else if (!run) begin
      sclk <= 1'b0;
    end else if (rise || fall) begin
      sclk <= ~sclk;
    end
  end

endmodule

// File: rtl/dfr_ctrl.sv
module dfr_ctrl
  import dfr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_dual_io,
  output logic             req_ready,
  input  logic             fall,
  input  logic             tick_lo,
  output phase_t           phase,
  output logic             dual_q,
  output logic             load,
  output logic             last_pair,
  output logic             cs_n,
  output logic             done
);

  logic [BEAT_W-1:0] beats;
  logic [LEN_W-1:0]  bytes_left;
  logic [1:0]        pair;
  logic              take;
  logic              empty_req;

  assign req_ready = (phase == PH_IDLE) && !done;
  assign take      = req_valid && req_ready;
  assign load      = take && (req_len != '0);
  assign empty_req = take && (req_len == '0);
  assign last_pair = (pair == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      dual_q     <= 1'b0;
      beats      <= '0;
      bytes_left <= '0;
      pair       <= '0;
      cs_n       <= 1'b1;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (empty_req) begin
            done <= 1'b1;
          end else if (load) begin
            phase      <= PH_CMD;
            beats      <= BEAT_W'(CMD_BEATS);
            dual_q     <= req_dual_io;
            bytes_left <= req_len;
            pair       <= '0;
            cs_n       <= 1'b0;
          end
        end
        PH_CMD: begin
          if (fall) begin
            if (beats == BEAT_W'(1)) begin
              phase <= PH_ADDR;
              beats <= dual_q ? BEAT_W'(ADDR2_BEATS) : BEAT_W'(ADDR1_BEATS);
            end else begin
              beats <= beats - BEAT_W'(1);
            end
          end
        end
        PH_ADDR: begin
          if (fall) begin
            if (beats == BEAT_W'(1)) begin
              phase <= dual_q ? PH_MODE : PH_DUMMY;
              beats <= dual_q ? BEAT_W'(MODE_BEATS) : BEAT_W'(DUMMY_BEATS);
            end else begin
              beats <= beats - BEAT_W'(1);
            end
          end
        end
        PH_MODE, PH_DUMMY: begin
          if (fall) begin
            if (beats == BEAT_W'(1)) begin
              phase <= PH_DATA;
            end else begin
              beats <= beats - BEAT_W'(1);
            end
          end
        end
        PH_DATA: begin
          if (fall) begin
            pair <= pair + 2'd1;
            if (last_pair) begin
              if (bytes_left == LEN_W'(1)) begin
                phase <= PH_END;
              end else begin
                bytes_left <= bytes_left - LEN_W'(1);
              end
            end
          end
        end
        PH_END: begin
          if (tick_lo) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dfr_tx_shift.sv
module dfr_tx_shift
  import dfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_dual_io,
  input  phase_t            phase,
  input  logic              dual_q,
  input  logic              fall,
  output logic              io0_out,
  output logic              io0_oe,
  output logic              io1_out,
  output logic              io1_oe
);

  localparam int SR_W = 8 + ADDR_W + 8;

  logic [SR_W-1:0] tx;
  logic            one_line;
  logic            two_line;

  assign one_line = (phase == PH_CMD) || ((phase == PH_ADDR) && !dual_q);
  assign two_line = ((phase == PH_ADDR) && dual_q) || (phase == PH_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx <= '0;
    end else if (load) begin
      tx <= {(req_dual_io ? CMD_DUAL_IO : CMD_DUAL_OUT), req_addr, MODE_BITS};
    end else if (fall && one_line) begin
      tx <= {tx[SR_W-2:0], 1'b0};
    end else if (fall && two_line) begin
      tx <= {tx[SR_W-3:0], 2'b00};
    end
  end

  always_comb begin
    io0_out = 1'b0;
    io0_oe  = 1'b0;
    io1_out = 1'b0;
    io1_oe  = 1'b0;
    if (one_line) begin
      io0_oe  = 1'b1;
      io0_out = tx[SR_W-1];
    end else if (two_line) begin
      io0_oe  = 1'b1;
      io1_oe  = 1'b1;
      io1_out = tx[SR_W-1];
      io0_out = tx[SR_W-2];
    end
  end

endmodule

// File: rtl/dfr_rx_pack.sv
module dfr_rx_pack
  import dfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_t     phase,
  input  logic       rise,
  input  logic       last_pair,
  input  logic       io0_in,
  input  logic       io1_in,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data
);

  logic [5:0] rx;
  logic       capture;

  assign capture = rise && (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (capture) begin
        if (last_pair) begin
          out_data  <= {rx, io1_in, io0_in};
          out_valid <= 1'b1;
        end else begin
          rx <= {rx[3:0], io1_in, io0_in};
        end
      end
    end
  end

endmodule

// File: rtl/dual_flash_reader.sv
module dual_flash_reader
  import dfr_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_dual_io,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic              io0_out,
  output logic              io0_oe,
  input  logic              io0_in,
  output logic              io1_out,
  output logic              io1_oe,
  input  logic              io1_in
);

  phase_t phase;
  logic   dual_q;
  logic   load;
  logic   last_pair;
  logic   run;
  logic   hold;
  logic   rise;
  logic   fall;
  logic   tick_lo;

  assign run  = (phase != PH_IDLE);
  assign hold = (phase == PH_END) ||
                ((phase == PH_DATA) && last_pair && out_valid && !out_ready);

  dfr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_len     (req_len),
    .req_dual_io (req_dual_io),
    .req_ready   (req_ready),
    .fall        (fall),
    .tick_lo     (tick_lo),
    .phase       (phase),
    .dual_q      (dual_q),
    .load        (load),
    .last_pair   (last_pair),
    .cs_n        (cs_n),
    .done        (done)
  );

  dfr_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .hold    (hold),
    .sclk    (sclk),
    .rise    (rise),
    .fall    (fall),
    .tick_lo (tick_lo)
  );

  dfr_tx_shift u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .req_addr    (req_addr),
    .req_dual_io (req_dual_io),
    .phase       (phase),
    .dual_q      (dual_q),
    .fall        (fall),
    .io0_out     (io0_out),
    .io0_oe      (io0_oe),
    .io1_out     (io1_out),
    .io1_oe      (io1_oe)
  );

  dfr_rx_pack u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .rise      (rise),
    .last_pair (last_pair),
    .io0_in    (io0_in),
    .io1_in    (io1_in),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/dfr_checker.sv
module dfr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       done,
  input logic       cs_n,
  input logic       sclk,
  input logic       io0_out,
  input logic       io0_oe,
  input logic       io1_out,
  input logic       io1_oe
);

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && !io0_oe && !io1_oe));

  assert_lines_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> ($stable(io0_out) && $stable(io1_out) &&
                               $stable(io0_oe) && $stable(io1_oe)));

  assert_line1_needs_line0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io1_oe |-> io0_oe);

  assert_stream_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

endmodule

bind dual_flash_reader dfr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .io0_out   (io0_out),
  .io0_oe    (io0_oe),
  .io1_out   (io1_out),
  .io1_oe    (io1_oe)
);

// File: tb/dual_flash_reader_tb.sv
module dual_flash_reader_tb;

  localparam int H     = 2;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [23:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_dual_io = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [7:0]       out_data;
  logic             done;
  logic             cs_n;
  logic             sclk;
  logic             io0_out, io0_oe, io1_out, io1_oe;
  logic             io0_in = 1'b0;
  logic             io1_in = 1'b0;

  always #4 clk = ~clk;

  dual_flash_reader #(.HALF_DIV(H), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_dual_io(req_dual_io),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .cs_n(cs_n), .sclk(sclk),
    .io0_out(io0_out), .io0_oe(io0_oe), .io0_in(io0_in),
    .io1_out(io1_out), .io1_oe(io1_oe), .io1_in(io1_in)
  );

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          finished = 1'b0;

  // bench view of the current transfer
  bit          cur_dual = 1'b0;
  logic [23:0] cur_addr = '0;
  int          cur_len = 0;
  int          start_beat = 40;
  int          f = 0;
  logic [7:0]  rx_cmd = '0;
  logic [23:0] rx_addr = '0;
  logic [7:0]  rx_mode = '0;
  int          bp = 0;
  int          run_cnt = 0;
  int          cyc = 0;
  int          cs_falls = 0;
  int          done_cnt = 0;
  logic        prev_sclk = 1'b0;
  logic        prev_cs = 1'b1;
  logic        prev_valid = 1'b0;
  logic        prev_ready = 1'b1;
  logic [7:0]  prev_data = '0;
  bit          stall_prev = 1'b0;
  logic [7:0]  exp_q[$];

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[3:0], a[23:20]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // cycle-by-cycle flash model and pin comparison
  always @(negedge clk) begin
    logic exp0;
    logic exp1;
    int   k;
    logic [7:0] b;
    logic [23:0] a;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_sim();
    end
    if (prev_cs && !cs_n) begin
      cs_falls++;
      f = 0; rx_cmd = '0; rx_addr = '0; rx_mode = 8'hFF;
    end
    // R6/R9: edge spacing
    if (!cs_n && !prev_sclk && sclk)
      chk((bp == 0) ? (run_cnt == H) : (run_cnt >= H), "R6 low time", run_cnt, H);
    if (prev_sclk && !sclk)
      chk(run_cnt == H, "R6 high time", run_cnt, H);
    if (!prev_cs && cs_n) begin
      chk(run_cnt == H && !sclk, "R9 deselect delay", run_cnt, H);
    end
    if ((sclk != prev_sclk) || (cs_n != prev_cs)) run_cnt = 1;
    else run_cnt++;
    // R7: clock must have paused
    if (stall_prev) chk(sclk == 1'b0, "R7 clock pause", sclk, 0);
    // master bits at rising edge
    if (!cs_n && !prev_sclk && sclk) begin
      if (f < 8) rx_cmd = {rx_cmd[6:0], io0_out};
      else if (cur_dual) begin
        if (f < 20) rx_addr = {rx_addr[21:0], io1_out, io0_out};
        else if (f < 24) rx_mode = {rx_mode[5:0], io1_out, io0_out};
      end else if (f < 32) rx_addr = {rx_addr[22:0], io0_out};
    end
    // slave drives after falling edge
    if (!cs_n && prev_sclk && !sclk) begin
      f++;
      if (f >= start_beat && (f - start_beat) < 4 * cur_len) begin
        k = f - start_beat;
        a = cur_addr + 24'(k / 4);
        b = mem_byte(a);
        b = b >> (6 - 2 * (k % 4));
        io1_in <= b[1];
        io0_in <= b[0];
      end
    end
    // R2/R3/R4: output enables per beat
    if (!cs_n) begin
      if (cur_dual) begin
        exp0 = (f < 24);
        exp1 = (f >= 8 && f < 24);
      end else begin
        exp0 = (f < 32);
        exp1 = 1'b0;
      end
      chk(io0_oe == exp0 && io1_oe == exp1, cur_dual ? "R4 line enables" : "R3 line enables",
          {io1_oe, io0_oe}, {exp1, exp0});
    end
    // R5/R8: stream
    if (prev_valid && prev_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 extra byte", prev_data, 0);
      else begin
        b = exp_q.pop_front();
        chk(prev_data == b, "R5 byte value", prev_data, b);
      end
    end
    if (prev_valid && !prev_ready)
      chk(out_valid && out_data == prev_data, "R8 held byte", {out_valid, out_data}, {1'b1, prev_data});
    if (done) begin
      done_cnt++;
      if (cur_len > 0) begin
        chk(cs_n == 1'b1, "R9 cs at done", cs_n, 1);
        chk(rx_cmd == (cur_dual ? 8'hBB : 8'h3B), "R2 command", rx_cmd, cur_dual ? 8'hBB : 8'h3B);
        chk(rx_addr == cur_addr, cur_dual ? "R4 address" : "R3 address", rx_addr, cur_addr);
        if (cur_dual) chk(rx_mode == 8'h00, "R4 mode bits", rx_mode, 0);
        chk(f == start_beat + 4 * cur_len, "R9 clock count", f, start_beat + 4 * cur_len);
      end
    end
    case (bp)
      0: out_ready <= 1'b1;
      1: out_ready <= (cyc % 3 == 0);
      default: out_ready <= (cyc % 45 >= 40);
    endcase
    prev_ready = (bp == 0) ? 1'b1 : ((bp == 1) ? (cyc % 3 == 0) : (cyc % 45 >= 40));
    stall_prev = !cs_n && !sclk && f >= start_beat && (f - start_beat) < 4 * cur_len &&
                 ((f - start_beat) % 4 == 3) && out_valid && !prev_ready;
    prev_valid = out_valid;
    prev_data  = out_data;
    prev_sclk  = sclk;
    prev_cs    = cs_n;
  end

  task automatic run_req(input bit dual, input logic [23:0] addr, input int len, input int mode);
    int d0;
    int falls0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    bp = mode;
    cur_dual = dual;
    cur_addr = addr;
    cur_len = len;
    start_beat = dual ? 24 : 40;
    for (int i = 0; i < len; i++) exp_q.push_back(mem_byte(addr + 24'(i)));
    d0 = done_cnt;
    falls0 = cs_falls;
    req_dual_io = dual;
    req_addr = addr;
    req_len = LEN_W'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1, "R10 immediate done", done, 1);
      @(negedge clk);
      chk(cs_falls == falls0 && cs_n, "R10 no select", cs_falls - falls0, 0);
    end else begin
      chk(req_ready == 1'b0, "R9 busy not ready", req_ready, 0);
      while (done_cnt == d0) @(negedge clk);
      while (exp_q.size() != 0) @(negedge clk);
      chk(cs_falls == falls0 + 1, "R9 one selection", cs_falls - falls0, 1);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(cs_n && !sclk && !io0_oe && !io1_oe, "R1 pins in reset", {cs_n, sclk, io0_oe, io1_oe}, 4'b1000);
    chk(!out_valid && !done, "R1 stream in reset", {out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(cs_n && !sclk && !out_valid, "R1 idle after reset", {cs_n, sclk, out_valid}, 3'b100);
    run_req(1'b0, 24'h012345, 5, 0);
    run_req(1'b1, 24'hABCDEF, 6, 0);
    run_req(1'b1, 24'hFFFFFE, 3, 1);
    run_req(1'b0, 24'h800001, 4, 2);
    run_req(1'b1, 24'h000010, 1, 2);
    run_req(1'b0, 24'h123456, 0, 0);
    run_req(1'b0, 24'h00FF00, 2, 1);
    run_req(1'b1, 24'h5A5A5A, 0, 0);
    finish_sim();
  end

endmodule